// File: doc/BRIEF.md
# I2C Acknowledge Phase Controller

This block runs the ninth-bit slot that follows each byte on an I2C bus. When the bit engine reports that a byte has finished, the block uses two control bits to decide whether an acknowledge clock follows. If a slot is opened, the block decides whether SDA is pulled low for that slot. When the local side is the sender, the block records the acknowledge value that the far side returned.

The two control bits are an acknowledge-clock enable and a programmed acknowledge level. The direction, address-phase flag and address-comparator result arrive as plain inputs. SCL edge strobes from the bit engine set the timing inside the slot. When an address byte is received with the programmed level at 0, the comparator result replaces that level. A matching address is acknowledged and a mismatch is left unanswered. A one-cycle completion pulse tells the bit engine when the acknowledge phase has ended.

Top module: `ackp_ctrl`

## Requirements
- R1: After reset, `ack_slot`, `sda_pull_low` and `ack_done` are 0, and `ack_rx` is 1.
- R2: With `ack_clk_en`=1, `ack_slot` rises in the cycle after the `byte_done` strobe. It falls in the cycle after the `scl_fall` strobe that ends the slot.
- R3: With `ack_clk_en`=0, no slot opens and `sda_pull_low` stays 0. `ack_done` is high for exactly the one cycle after `byte_done`.
- R4: When receiving a byte that is not an address, `sda_pull_low` is 1 during the slot when `ack_level`=0 and 0 when `ack_level`=1.
- R5: When receiving an address byte with `ack_level`=0, `sda_pull_low` during the slot equals `addr_match`: 1 pulls SDA low and 0 leaves it released.
- R6: When receiving an address byte with `ack_level`=1, SDA is released whatever `addr_match` is.
- R7: When transmitting (`is_tx`=1), `sda_pull_low` stays 0 during the slot.
- R8: In a transmit slot, `sda_in` is captured into `ack_rx` on the `scl_rise` strobe and is visible in the next cycle (0 means acknowledged, 1 means not acknowledged). Receive slots and disabled slots leave `ack_rx` unchanged.
- R9: `sda_pull_low` changes only in the cycle after `byte_done` (SCL low) or in the cycle after `scl_fall`. It never changes while SCL is high.
- R10: `ack_done` is high for exactly the one cycle after the `scl_fall` strobe that closes a slot.
- R11: The control inputs are taken at `byte_done`. Changes to them during a slot, and further `byte_done` strobes during a slot, have no effect on `sda_pull_low`, `ack_slot` or the capture of `ack_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_clk_en | input | 1 | 1: a ninth clock follows each byte |
| ack_level | input | 1 | Programmed acknowledge level when receiving (0 pulls low) |
| is_tx | input | 1 | 1: local side is sending the byte |
| addr_phase | input | 1 | 1: the current byte is an address byte |
| addr_match | input | 1 | Result from the slave address comparator |
| byte_done | input | 1 | Strobe: eighth bit completed, SCL low |
| scl_rise | input | 1 | Strobe: SCL rising edge |
| scl_fall | input | 1 | Strobe: SCL falling edge |
| sda_in | input | 1 | Sampled SDA line level |
| ack_slot | output | 1 | High while the ninth clock is in progress |
| sda_pull_low | output | 1 | 1 drives SDA low |
| ack_rx | output | 1 | Last acknowledge received while sending |
| ack_done | output | 1 | One-cycle pulse at the end of the acknowledge phase |

## Verification
The hardest case to reach is a slot in which the inputs move after the decision has been made. In that case the control bits flip and a stray `byte_done` arrives while `ack_slot` is high, and the drive and the captured acknowledge must keep the values fixed at slot entry. The random transactions often insert such a disturbance between slot entry and the rising strobe. The bench then checks that the drive level and the later capture still follow the original settings. Directed runs cover every combination of the two control bits with both directions, and address match and mismatch.

// File: rtl/ackp_pkg.sv
package ackp_pkg;
  typedef enum logic [0:0] {PH_IDLE = 1'b0, PH_SLOT = 1'b1} ack_phase_t;

  typedef struct packed {
    logic clk_en;
    logic level;
    logic tx;
    logic addr;
    logic match;
  } ack_ctrl_t;
endpackage

// File: rtl/ackp_level_sel.sv
module ackp_level_sel
  import ackp_pkg::*;
(
  input  ack_ctrl_t ctrl,
  output logic      pull_low
);
  // Sender always releases; address reception with level 0 follows the comparator.
  always_comb begin
    if (ctrl.tx)
      pull_low = 1'b0;
    else if (ctrl.addr && !ctrl.level)
      pull_low = ctrl.match;
    else
      pull_low = !ctrl.level;
  end
endmodule

// File: rtl/ackp_slot_fsm.sv
module ackp_slot_fsm
  import ackp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ack_ctrl_t ctrl,
  input  logic      pull_req,
  input  logic      byte_done,
  input  logic      scl_fall,
  output logic      ack_slot,
  output logic      drive_low,
  output logic      tx_q,
  output logic      done
);
  ack_phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      drive_low <= 1'b0;
      tx_q      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (byte_done) begin
            if (ctrl.clk_en) begin
              phase     <= PH_SLOT;
              drive_low <= pull_req;
              tx_q      <= ctrl.tx;
            end else begin
              done <= 1'b1;
            end
          end
        end
        PH_SLOT: begin
          if (scl_fall) begin
            phase     <= PH_IDLE;
            drive_low <= 1'b0;
            done      <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ack_slot = (phase == PH_SLOT);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DRV_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(drive_low) |-> ($past(byte_done) || $past(scl_fall))); // R9
  AST_NOCLK_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ctrl.clk_en && !ack_slot) |=> (done && !ack_slot)); // R3
endmodule

// File: rtl/ackp_sampler.sv
module ackp_sampler #(
  parameter logic RX_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic sda_in,
  output logic ack_rx
);
  always_ff @(posedge clk) begin
    if (rst)
      ack_rx <= RX_RESET;
    else if (take)
      ack_rx <= sda_in;
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(ack_rx)); // R8
endmodule

// File: rtl/ackp_ctrl.sv
module ackp_ctrl
  import ackp_pkg::*;
#(
  parameter logic RX_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_clk_en,
  input  logic ack_level,
  input  logic is_tx,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic byte_done,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  output logic ack_slot,
  output logic sda_pull_low,
  output logic ack_rx,
  output logic ack_done
);
  ack_ctrl_t ctrl;
  logic      pull_req;
  logic      tx_q;

  assign ctrl = '{clk_en: ack_clk_en, level: ack_level, tx: is_tx,
                  addr: addr_phase, match: addr_match};

  ackp_level_sel u_sel (.ctrl(ctrl), .pull_low(pull_req));

  ackp_slot_fsm u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl), .pull_req(pull_req),
    .byte_done(byte_done), .scl_fall(scl_fall),
    .ack_slot(ack_slot), .drive_low(sda_pull_low), .tx_q(tx_q), .done(ack_done)
  );

  ackp_sampler #(.RX_RESET(RX_RESET)) u_smp (
    .clk(clk), .rst(rst), .take(ack_slot && tx_q && scl_rise),
    .sda_in(sda_in), .ack_rx(ack_rx)
  );

  AST_DRV_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    sda_pull_low |-> ack_slot); // R2
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ack_slot && tx_q) |-> !sda_pull_low); // R7
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_slot && !scl_fall) |=> (ack_slot && $stable(sda_pull_low))); // R11
endmodule

// File: tb/tb_ackp_ctrl.sv
`timescale 1ns/1ps
module tb_ackp_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_clk_en = 0, ack_level = 0, is_tx = 0, addr_phase = 0, addr_match = 0;
  logic byte_done = 0, scl_rise = 0, scl_fall = 0, sda_in = 1;
  logic ack_slot, sda_pull_low, ack_rx, ack_done;

  int checks = 0;
  int fails  = 0;
  logic exp_rx = 1'b1;

  always #10 clk = ~clk;

  ackp_ctrl dut (
    .clk(clk), .rst(rst), .ack_clk_en(ack_clk_en), .ack_level(ack_level),
    .is_tx(is_tx), .addr_phase(addr_phase), .addr_match(addr_match),
    .byte_done(byte_done), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .ack_slot(ack_slot), .sda_pull_low(sda_pull_low),
    .ack_rx(ack_rx), .ack_done(ack_done)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic exp_pull(input logic lvl, tx, addr, match);
    if (tx) return 1'b0;
    if (addr && !lvl) return match;
    return !lvl;
  endfunction

  function automatic string drive_tag(input logic lvl, tx, addr);
    if (tx) return "R7 tx release";
    if (addr && !lvl) return "R5 address override";
    if (addr) return "R6 address level 1";
    return "R4 data level";
  endfunction

  task automatic run_byte(input logic en, lvl, tx, addr, match, sda, poke);
    logic ep;
    ep = exp_pull(lvl, tx, addr, match);
    @(negedge clk);
    ack_clk_en = en; ack_level = lvl; is_tx = tx; addr_phase = addr; addr_match = match;
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
    if (!en) begin
      check("R3 done pulse", ack_done, 1'b1);
      check("R3 no slot", ack_slot, 1'b0);
      check("R3 no drive", sda_pull_low, 1'b0);
      @(negedge clk);
      check("R3 done one cycle", ack_done, 1'b0);
      check("R8 rx unchanged", ack_rx, exp_rx);
      return;
    end
    check("R2 slot open", ack_slot, 1'b1);
    check(drive_tag(lvl, tx, addr), sda_pull_low, ep);
    if (poke) begin
      ack_level = ~lvl; addr_match = ~match; is_tx = ~tx; addr_phase = ~addr;
      ack_clk_en = ~en; byte_done = 1'b1;
      @(negedge clk);
      byte_done = 1'b0;
      check("R11 drive held", sda_pull_low, ep);
      check("R11 slot held", ack_slot, 1'b1);
    end
    scl_rise = 1'b1; sda_in = sda;
    @(negedge clk);
    scl_rise = 1'b0;
    if (tx) exp_rx = sda;
    check("R9 drive stable SCL high", sda_pull_low, ep);
    check("R8 ack_rx", ack_rx, exp_rx);
    check("R10 no early done", ack_done, 1'b0);
    scl_fall = 1'b1;
    @(negedge clk);
    scl_fall = 1'b0;
    check("R10 done pulse", ack_done, 1'b1);
    check("R2 slot closed", ack_slot, 1'b0);
    check("R9 drive released", sda_pull_low, 1'b0);
    @(negedge clk);
    check("R10 done one cycle", ack_done, 1'b0);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 slot reset", ack_slot, 1'b0);
    check("R1 drive reset", sda_pull_low, 1'b0);
    check("R1 done reset", ack_done, 1'b0);
    check("R1 rx reset", ack_rx, 1'b1);
    // every combination of enable, level and direction
    for (int k = 0; k < 8; k++)
      run_byte(k[2], k[1], k[0], 1'b0, 1'b0, 1'b0, 1'b0);
    // address reception: match and mismatch at both levels
    run_byte(1, 0, 0, 1, 1, 1, 0);
    run_byte(1, 0, 0, 1, 0, 1, 0);
    run_byte(1, 1, 0, 1, 1, 0, 0);
    run_byte(1, 1, 0, 1, 0, 0, 0);
    // transmit nack then receive slot leaves ack_rx alone
    run_byte(1, 0, 1, 1, 0, 1, 0);
    run_byte(1, 0, 0, 0, 0, 0, 1);
    run_byte(1, 1, 1, 0, 0, 0, 1);
    for (int n = 0; n < 60; n++) begin
      logic [6:0] r;
      r = 7'($urandom);
      run_byte(r[0] | r[1], r[2], r[3], r[4], r[5], r[6], 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule